// File: doc/BRIEF.md
# Mode-Banked Page Register File

This block holds the page address and page descriptor words of a 16-bit memory management unit. It keeps a separate table for each of the three privilege levels: kernel, supervisor and user. Each table has eight instruction-space pages and eight data-space pages. A word-wide bus reaches every table at a fixed octal window, whatever mode the processor is running in. The same bus also reads two derived values. The first is a live status word built from the current mode and the program counter. The second is a constant that reports the size of installed memory.

A second port, used only for lookup, takes a mode code, a space bit and a page number. It returns the matching address word and descriptor word at once, so that an address translator beside this block can use them. Bus reads are registered and return data one cycle after the address is presented. Writes take effect on the clock edge.

Top module: `mmu_page_regs`

## Requirements
- R1: While `rst` is sampled high, every stored word is cleared to zero. The cycle after a reset edge shows `bus_rdata` = 16'hFFFF and `bus_hit` = 0.
- R2: The window block is chosen by `bus_addr[15:6]`: octal 01722 selects supervisor (mode code 1), 01723 selects kernel (code 0) and 01776 selects user (code 3). Inside a block, bit 5 selects the address word (1) or the descriptor word (0), bit 4 selects data space (1) or instruction space (0), and bits 3:1 give the page number. Bit 0 is ignored.
- R3: A bus write with `bus_wr` = 1 to a page-register address stores `bus_wdata`. The read data and hit flag for an address presented in cycle N appear on `bus_rdata`/`bus_hit` after the edge that ends cycle N.
- R4: When a write and a read of the same page register fall in the same cycle, the registered read returns the value held before that write. The new value appears on the next read.
- R5: Which mode's registers the bus reaches depends only on the address, never on `cur_mode`.
- R6: A read of 16'o177572 returns `cur_mode` in bits 6:5, `cur_pc[15:13]` in bits 3:1, and zero in bits 15:7, bit 4 and bit 0. A write to this address changes nothing.
- R7: A read of 16'o177760 returns the low 16 bits of NUM_PAGES*8192 - 4097. This is 16'h6FFF for the default NUM_PAGES = 12. A write to this address changes nothing.
- R8: Any other address, including 16'o177573 and every address outside the three window blocks, reads as 16'hFFFF with `bus_hit` = 0. A write to such an address changes no stored word.
- R9: `bus_hit` is 1 for a read of any page-register address, of the status address or of the size address.
- R10: The lookup port returns the words stored at {`lk_mode`, `lk_dspace`, `lk_page`} without a clock. A word written at an edge is visible on the lookup outputs right after that edge. Mode code 2 has no registers and always looks up as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Byte address of the bus access |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data for the previous cycle's address |
| bus_hit | output | 1 | Registered flag: the previous cycle's address decoded to a register |
| cur_mode | input | 2 | Current processor mode code |
| cur_pc | input | 16 | Current program counter |
| lk_mode | input | 2 | Lookup mode code |
| lk_dspace | input | 1 | Lookup space: 1 for data, 0 for instruction |
| lk_page | input | 3 | Lookup page number |
| lk_par | output | 16 | Looked-up page address word |
| lk_pdr | output | 16 | Looked-up page descriptor word |

## Verification
Two things can happen to one page register in the same cycle. A bus write can coincide with the registered read of the same address. That same write can also coincide with the lookup port selecting the entry being written. The bench writes the same address on back-to-back cycles and then reads it. A read-first result is expected after the colliding edge and the new value one cycle later. Meanwhile the lookup index steps through every entry, so some writes land on the entry under lookup. The lookup output is then expected to show the new word at once.

// File: rtl/mmu_regs_pkg.sv
package mmu_regs_pkg;
  localparam int DW    = 16;
  localparam int IDX_W = 6;   // {mode[1:0], dspace, page[2:0]}

  // address bits [15:6] of each mode's 32-word block
  localparam logic [9:0] SUPV_BLK = 10'o1722;
  localparam logic [9:0] KERN_BLK = 10'o1723;
  localparam logic [9:0] USER_BLK = 10'o1776;

  localparam logic [15:0] STAT_ADDR = 16'o177572;
  localparam logic [15:0] SIZE_ADDR = 16'o177760;

  typedef enum logic [1:0] {
    MODE_KERN = 2'd0,
    MODE_SUPV = 2'd1,
    MODE_RSVD = 2'd2,
    MODE_USER = 2'd3
  } mmu_mode_e;

  typedef struct packed {
    logic             pg_hit;
    logic             stat_hit;
    logic             size_hit;
    logic             is_par;
    logic [IDX_W-1:0] idx;
  } dec_t;
endpackage

// File: rtl/mmu_addr_decode.sv
module mmu_addr_decode
  import mmu_regs_pkg::*;
(
  input  logic [15:0] addr,
  output dec_t        dec
);
  mmu_mode_e mode_sel;

  always_comb begin
    dec      = '0;
    mode_sel = MODE_KERN;
    case (addr[15:6])
      SUPV_BLK: begin dec.pg_hit = 1'b1; mode_sel = MODE_SUPV; end
      KERN_BLK: begin dec.pg_hit = 1'b1; mode_sel = MODE_KERN; end
      USER_BLK: begin dec.pg_hit = 1'b1; mode_sel = MODE_USER; end
      default:  ;
    endcase
    dec.is_par   = dec.pg_hit & addr[5];
    dec.idx      = dec.pg_hit ? {mode_sel, addr[4], addr[3:1]} : '0;
    dec.stat_hit = (addr == STAT_ADDR);
    dec.size_hit = (addr == SIZE_ADDR);
  end
endmodule

// File: rtl/mmu_reg_bank.sv
module mmu_reg_bank #(
  parameter int DW    = 16,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [DW-1:0]    wdata,
  input  logic [IDX_W-1:0] ridx_a,
  output logic [DW-1:0]    rdata_a,
  input  logic [IDX_W-1:0] ridx_b,
  output logic [DW-1:0]    rdata_b
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[widx] <= wdata;
    end
  end

  assign rdata_a = mem[ridx_a];
  assign rdata_b = mem[ridx_b];

  // R3
  bank_store_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> (mem[$past(widx)] == $past(wdata)));
endmodule

// File: rtl/mmu_status_regs.sv
module mmu_status_regs #(
  parameter int NUM_PAGES = 12
) (
  input  logic [1:0]  cur_mode,
  input  logic [15:0] cur_pc,
  output logic [15:0] stat_val,
  output logic [15:0] size_val
);
  localparam logic [31:0] SIZE_FULL = 32'(NUM_PAGES) * 32'd8192 - 32'd4097;

  assign stat_val = {9'd0, cur_mode, 1'b0, cur_pc[15:13], 1'b0};
  assign size_val = SIZE_FULL[15:0];
endmodule

// File: rtl/mmu_page_regs.sv
module mmu_page_regs
  import mmu_regs_pkg::*;
#(
  parameter int NUM_PAGES = 12
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] bus_addr,
  input  logic        bus_wr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        bus_hit,
  input  logic [1:0]  cur_mode,
  input  logic [15:0] cur_pc,
  input  logic [1:0]  lk_mode,
  input  logic        lk_dspace,
  input  logic [2:0]  lk_page,
  output logic [15:0] lk_par,
  output logic [15:0] lk_pdr
);
  localparam int NKIND = 2;   // 0: descriptor, 1: address word

  dec_t             dec;
  logic [IDX_W-1:0] lk_idx;
  logic [DW-1:0]    rd_bus [NKIND];
  logic [DW-1:0]    rd_lk  [NKIND];
  logic [DW-1:0]    stat_val, size_val;
  logic             any_hit;

  mmu_addr_decode u_dec (.addr(bus_addr), .dec(dec));

  mmu_status_regs #(.NUM_PAGES(NUM_PAGES)) u_stat (
    .cur_mode(cur_mode), .cur_pc(cur_pc),
    .stat_val(stat_val), .size_val(size_val)
  );

  assign lk_idx = {lk_mode, lk_dspace, lk_page};

  for (genvar k = 0; k < NKIND; k++) begin : g_bank
    mmu_reg_bank #(.DW(DW), .IDX_W(IDX_W)) u_bank (
      .clk    (clk),
      .rst    (rst),
      .we     (bus_wr && dec.pg_hit && (dec.is_par == (k == 1))),
      .widx   (dec.idx),
      .wdata  (bus_wdata),
      .ridx_a (dec.idx),
      .rdata_a(rd_bus[k]),
      .ridx_b (lk_idx),
      .rdata_b(rd_lk[k])
    );
  end

  assign lk_pdr  = rd_lk[0];
  assign lk_par  = rd_lk[1];
  assign any_hit = dec.pg_hit | dec.stat_hit | dec.size_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= 16'hFFFF;
      bus_hit   <= 1'b0;
    end else begin
      bus_hit <= any_hit;
      if (dec.pg_hit)        bus_rdata <= dec.is_par ? rd_bus[1] : rd_bus[0];
      else if (dec.stat_hit) bus_rdata <= stat_val;
      else if (dec.size_hit) bus_rdata <= size_val;
      else                   bus_rdata <= 16'hFFFF;
    end
  end

  // R2
  dec_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({dec.pg_hit, dec.stat_hit, dec.size_hit}));

  // R10
  no_mode2_chk: assert property (@(posedge clk) disable iff (rst)
    dec.pg_hit |-> (dec.idx[5:4] != 2'b10));

  // R8
  unmapped_ffff_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!any_hit)) |-> (bus_rdata == 16'hFFFF && !bus_hit));

  // R6
  stat_fmt_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(dec.stat_hit)) |->
      (bus_rdata[15:7] == 9'd0 && bus_rdata[4] == 1'b0 && bus_rdata[0] == 1'b0 &&
       bus_rdata[6:5] == $past(cur_mode) && bus_hit));

  // R7
  size_const_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(dec.size_hit)) |-> $stable(bus_rdata) || $past(!dec.size_hit, 2) || $past(rst, 2));
endmodule

// File: tb/mmu_page_regs_tb.sv
module mmu_page_regs_tb;
  localparam int NUM_PAGES = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_hit;
  logic [1:0]  cur_mode = 2'd0;
  logic [15:0] cur_pc = '0;
  logic [1:0]  lk_mode = '0;
  logic        lk_dspace = 1'b0;
  logic [2:0]  lk_page = '0;
  logic [15:0] lk_par, lk_pdr;

  always #5 clk = ~clk;

  mmu_page_regs #(.NUM_PAGES(NUM_PAGES)) u_dut (.*);

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  int lk_cnt = 0;
  int ref_par [64];
  int ref_pdr [64];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // decode by address ranges; returns slot or -1
  function automatic int ref_slot(input logic [15:0] a, output bit par);
    int m, off, grp;
    par = 1'b0;
    if (a >= 16'o172200 && a < 16'o172300) begin m = 1; off = int'(a) - 'o172200; end
    else if (a >= 16'o172300 && a < 16'o172400) begin m = 0; off = int'(a) - 'o172300; end
    else if (a >= 16'o177600 && a < 16'o177700) begin m = 3; off = int'(a) - 'o177600; end
    else return -1;
    grp = off / 16;
    par = (grp >= 2);
    return m * 16 + (grp % 2) * 8 + (off % 16) / 2;
  endfunction

  function automatic logic [15:0] win_addr(input int m, input int grp, input int pg);
    int base;
    case (m)
      0: base = 'o172300;
      1: base = 'o172200;
      default: base = 'o177600;
    endcase
    return 16'(base + grp * 16 + pg * 2);
  endfunction

  task automatic step(input logic [15:0] a, input logic w, input logic [15:0] d,
                      input string tag);
    int exp_rd, exp_hit, slot, li;
    bit par;
    string rtag;
    @(negedge clk);
    bus_addr = a; bus_wr = w; bus_wdata = d;
    li = lk_cnt % 64;
    lk_mode = 2'(li / 16); lk_dspace = 1'((li / 8) % 2); lk_page = 3'(li % 8);
    @(posedge clk);
    #1;
    if (rst) begin
      for (int i = 0; i < 64; i++) begin ref_par[i] = 0; ref_pdr[i] = 0; end
      exp_rd = 'hFFFF; exp_hit = 0; rtag = "R1";
    end else begin
      slot = ref_slot(a, par);
      if (slot >= 0) begin
        exp_rd = par ? ref_par[slot] : ref_pdr[slot]; exp_hit = 1; rtag = "R3";
        if (w) begin
          if (par) ref_par[slot] = int'(d); else ref_pdr[slot] = int'(d);
        end
      end else if (a == 16'o177572) begin
        exp_rd = (int'(cur_mode) << 5) | ((int'(cur_pc) >> 13) << 1); exp_hit = 1; rtag = "R6";
      end else if (a == 16'o177760) begin
        exp_rd = (NUM_PAGES * 8192 - 4097) % 65536; exp_hit = 1; rtag = "R7";
      end else begin
        exp_rd = 'hFFFF; exp_hit = 0; rtag = "R8";
      end
    end
    if (tag != "") rtag = tag;
    chk(int'(bus_rdata) == exp_rd, rtag, "bus_rdata", int'(bus_rdata), exp_rd);
    chk(int'(bus_hit) == exp_hit, rst ? "R1" : "R9", "bus_hit", int'(bus_hit), exp_hit);
    chk(int'(lk_par) == ref_par[li], "R10", "lk_par", int'(lk_par), ref_par[li]);
    chk(int'(lk_pdr) == ref_pdr[li], "R10", "lk_pdr", int'(lk_pdr), ref_pdr[li]);
    lk_cnt++;
  endtask

  initial begin
    int modes [3] = '{0, 1, 3};
    int n;
    // reset
    for (int i = 0; i < 3; i++) step(16'o172300, 1'b0, '0, "R1");
    rst = 1'b0;
    step(16'o000000, 1'b0, '0, "");
    // fill every register while cur_mode wanders
    n = 0;
    for (int mi = 0; mi < 3; mi++)
      for (int g = 0; g < 4; g++)
        for (int p = 0; p < 8; p++) begin
          cur_mode = 2'(modes[(n + 1) % 3]);
          step(win_addr(modes[mi], g, p), 1'b1, 16'(16'hA5C3 ^ (n * 16'h0137)), "R5");
          n++;
        end
    // read back, odd byte addresses on odd pages
    for (int mi = 0; mi < 3; mi++)
      for (int g = 0; g < 4; g++)
        for (int p = 0; p < 8; p++) begin
          cur_mode = 2'(modes[(mi + 2) % 3]);
          step(win_addr(modes[mi], g, p) | 16'(p % 2), 1'b0, '0, (p % 2) ? "R2" : "R5");
        end
    // same-cycle write and read of one register
    step(16'o177646, 1'b1, 16'h1111, "R4");
    step(16'o177646, 1'b1, 16'h2222, "R4");
    step(16'o177646, 1'b0, 16'h0000, "R4");
    step(16'o172366, 1'b1, 16'h3333, "R4");
    step(16'o172366, 1'b0, 16'h0000, "R4");
    // status word under several modes and PCs
    for (int i = 0; i < 8; i++) begin
      cur_mode = 2'(modes[i % 3]);
      cur_pc = 16'(i * 16'h2000 + 16'h0ABC);
      step(16'o177572, 1'b0, '0, "R6");
    end
    step(16'o177572, 1'b1, 16'h5555, "R6");
    step(16'o177572, 1'b0, '0, "R6");
    // size constant, write ignored
    step(16'o177760, 1'b0, '0, "R7");
    step(16'o177760, 1'b1, 16'h0000, "R7");
    step(16'o177760, 1'b0, '0, "R7");
    // unmapped addresses: read and write
    step(16'o172400, 1'b1, 16'hDEAD, "R8");
    step(16'o172176, 1'b1, 16'hDEAD, "R8");
    step(16'o177700, 1'b1, 16'hDEAD, "R8");
    step(16'o177573, 1'b0, '0, "R8");
    step(16'o177574, 1'b1, 16'hBEEF, "R8");
    step(16'o177500, 1'b0, '0, "R8");
    // sweep lookup across all entries, including mode code 2
    for (int i = 0; i < 64; i++) step(16'o000002, 1'b0, '0, "R8");
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000ns;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule